// File: doc/BRIEF.md
# Time-of-Day Transfer Control Unit

This unit sits between a chip-level time-of-day source and a set of processor cores. Software programs it through a simple write bus (address, 64-bit data and a write enable). It first names a destination core by writing a target-select word, which the unit decodes in one of two ways. The first way gives the full 32-bit register address of the core's time-of-day register. The second gives a short 5-bit core number. The decoded result is matched against a parameter table of per-core register bases or core numbers, and the winning core index is latched.

A later move command asks for the time-of-day value to be pushed into that core's timebase. The move goes ahead only if the unit is running, the command bit is set, a target is latched and the core reports that it is ready. When all of these hold, the core's "sent" flag is raised, and it stays raised until that core acknowledges. Every rejected command sets a sticky bit in a write-1-to-clear error register and pulses a guest-error line for one clock. The unit also holds a 32-bit control field.

The unit has two states, with named transitions. In STOPPED, the START command moves it to RUNNING (transition T_START). In RUNNING, the STOP command moves it back to STOPPED (transition T_STOP). A command issued in the wrong state leaves the state as it is and records an error. A parameter switch removes core-number decoding entirely.

Top module: `tod_xfer_ctrl`

## Requirements
- R1: After reset the unit is STOPPED, no target is latched (target index 0), and the error register, control field, sent flags and guest-error line are all zero.
- R2: A write to register 2 with data bit 28 set (bit 35 counted from the MSB) uses address mode. The address is data[63:32]. When its low 12 bits equal TOD_OFS, the address with those 12 bits cleared is compared against each core base. The lowest-numbered matching core is latched and target-valid is set.
- R3: An address-mode write whose low 12 bits differ from TOD_OFS, or whose base matches no core, clears target-valid and sets error bit 5.
- R4: A write to register 2 with data bit 28 clear uses core-number mode when it is enabled. The number is data[36:32], masked to 5 bits, and the lowest core whose configured number matches is latched. If no core matches, error bit 5 is set and target-valid is cleared.
- R5: With CORE_ID_MODE_EN = 0, a core-number-mode write latches no target, clears target-valid and sets error bit 6.
- R6: A write to register 4 (START) moves STOPPED to RUNNING. In RUNNING it sets error bit 0 instead. A write to register 5 (STOP) moves RUNNING to STOPPED. In STOPPED it sets error bit 7 instead.
- R7: A write to register 3 (MOVE) is checked in this order. If the unit is not RUNNING, error bit 1 is set. Otherwise, if data bit 63 (bit 0 from the MSB) is clear, error bit 2 is set. Otherwise, if no target is valid, error bit 3 is set.
- R8: A MOVE that passes R7 sets the sent flag of the latched core when that core's ready input is high. When the ready input is low, it sets error bit 4 and changes no sent flag.
- R9: A sent flag stays set until the matching acknowledge input is high at a clock edge, and it is then cleared.
- R10: A write to register 1 clears each error bit whose data bit is 1 and leaves the other error bits unchanged.
- R11: A write to register 0 loads data[63:32] (bits 0 to 31 from the MSB) into the control field. The lower half of the data is dropped.
- R12: The guest-error output is high for exactly the one cycle after each write that sets an error bit, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Register select (0 control, 1 error, 2 target, 3 move, 4 start, 5 stop) |
| wr_data | input | 64 | Write data |
| core_ready | input | N_CORES | Per-core timebase ready for time-of-day |
| core_ack | input | N_CORES | Per-core acknowledge that clears the sent flag |
| running | output | 1 | High in the RUNNING state |
| tgt_valid | output | 1 | A destination core is latched |
| tgt_idx | output | IDX_W | Latched destination core index |
| err_bits | output | 8 | Sticky error register |
| ctrl_bits | output | 32 | Control field |
| sent | output | N_CORES | Per-core time-of-day sent to timebase flags |
| guest_err | output | 1 | One-cycle pulse on a rejected write |

## Verification
On every cycle, the assertions check the following. A sent flag rises only on a core whose ready input was high. Once raised, it holds until that core's acknowledge arrives. Error bits never clear without an error-register write. The control field changes only on its own write. RUNNING is entered only through START. A latched index is always in range. The directed scenarios are needed to show the things that depend on the whole decode path. These are which core wins for a given select word, the priority among the move guards, the bit-5/bit-6 distinction between modes, first-match ordering with duplicated bases, and partial write-1-to-clear masks.

// File: rtl/tod_xfer_pkg.sv
package tod_xfer_pkg;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } tod_state_e;

    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] RA_CTRL   = 3'd0;
    localparam logic [REG_AW-1:0] RA_ERR    = 3'd1;
    localparam logic [REG_AW-1:0] RA_TARGET = 3'd2;
    localparam logic [REG_AW-1:0] RA_MOVE   = 3'd3;
    localparam logic [REG_AW-1:0] RA_START  = 3'd4;
    localparam logic [REG_AW-1:0] RA_STOP   = 3'd5;

    localparam int DATA_W = 64;
    localparam int ERR_W  = 8;

    // error bit positions
    localparam int EB_START_STATE = 0;
    localparam int EB_MOVE_STATE  = 1;
    localparam int EB_MOVE_CMD    = 2;
    localparam int EB_MOVE_NOTGT  = 3;
    localparam int EB_MOVE_NRDY   = 4;
    localparam int EB_DECODE      = 5;
    localparam int EB_UNIMPL      = 6;
    localparam int EB_STOP_STATE  = 7;

    // MSB-0 bit b of a 64-bit word sits at LSB index 63-b
    localparam int SEL_MODE_BIT = DATA_W - 1 - 35;
    localparam int MOVE_CMD_BIT = DATA_W - 1 - 0;

    localparam int CID_W = 5;
    localparam int OFS_W = 12;

endpackage

// File: rtl/tod_target_decode.sv
module tod_target_decode
    import tod_xfer_pkg::*;
#(
    parameter int               N_CORES         = 4,
    parameter int               IDX_W           = 2,
    parameter logic [32*N_CORES-1:0] CORE_BASES = '0,
    parameter logic [CID_W*N_CORES-1:0] CORE_IDS = '0,
    parameter logic [OFS_W-1:0] TOD_OFS         = 12'h3A4,
    parameter bit               CORE_ID_MODE_EN = 1'b1
) (
    input  logic [31:0]      sel_hi,
    input  logic             sel_mode,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic             unimpl
);

    logic [31:0]        base_part;
    logic               ofs_ok;
    logic [CID_W-1:0]   cid;
    logic [N_CORES-1:0] addr_match;
    logic [N_CORES-1:0] id_match;
    logic [N_CORES-1:0] id_sel;
    logic [N_CORES-1:0] match;

    assign base_part = {sel_hi[31:OFS_W], {OFS_W{1'b0}}};
    assign ofs_ok    = (sel_hi[OFS_W-1:0] == TOD_OFS);
    assign cid       = sel_hi[CID_W-1:0];

    for (genvar g = 0; g < N_CORES; g++) begin : g_cmp
        assign addr_match[g] = (base_part == CORE_BASES[g*32 +: 32]);
        assign id_match[g]   = (cid == CORE_IDS[g*CID_W +: CID_W]);
    end

    if (CORE_ID_MODE_EN) begin : g_id_on
        assign id_sel = id_match;
        assign unimpl = 1'b0;
    end else begin : g_id_off
        assign id_sel = '0;
        assign unimpl = ~sel_mode;
        logic unused_id;
        assign unused_id = ^id_match;
    end

    assign match = sel_mode ? (ofs_ok ? addr_match : '0) : id_sel;

    // lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_CORES - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tod_err_reg.sv
module tod_err_reg
    import tod_xfer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic [ERR_W-1:0] clr_mask,
    input  logic [ERR_W-1:0] set_vec,
    output logic [ERR_W-1:0] err
);

    logic [ERR_W-1:0] clr_eff;
    assign clr_eff = clr_en ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err <= '0;
        end else begin
            err <= (err & ~clr_eff) | set_vec;
        end
    end

    // R10: no bit drops without a clearing write
    p_no_silent_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((err & $past(err)) == $past(err)));

endmodule

// File: rtl/tod_sent_flags.sv
module tod_sent_flags #(
    parameter int N_CORES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CORES-1:0] set_vec,
    input  logic [N_CORES-1:0] ready,
    input  logic [N_CORES-1:0] ack,
    output logic [N_CORES-1:0] sent
);

    for (genvar g = 0; g < N_CORES; g++) begin : g_core
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sent[g] <= 1'b0;
            end else if (set_vec[g]) begin
                sent[g] <= 1'b1;
            end else if (ack[g]) begin
                sent[g] <= 1'b0;
            end
        end

        // R8: a flag rises only for a core that was ready
        p_sent_needs_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sent[g]) |-> $past(ready[g]));

        // R9: flag holds until acknowledged
        p_sent_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (sent[g] && !ack[g]) |=> sent[g]);

        // R9: acknowledge clears when no new set arrives
        p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[g] && !set_vec[g]) |=> !sent[g]);
    end

endmodule

// File: rtl/tod_xfer_ctrl.sv
module tod_xfer_ctrl
    import tod_xfer_pkg::*;
#(
    parameter int N_CORES = 4,
    parameter logic [32*N_CORES-1:0] CORE_BASES =
        {32'h2300_0000, 32'h2200_0000, 32'h2100_0000, 32'h2000_0000},
    parameter logic [5*N_CORES-1:0] CORE_IDS =
        {5'd13, 5'd9, 5'd5, 5'd1},
    parameter logic [11:0] TOD_OFS = 12'h3A4,
    parameter bit CORE_ID_MODE_EN = 1'b1,
    parameter int IDX_W = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [2:0]         wr_addr,
    input  logic [63:0]        wr_data,
    input  logic [N_CORES-1:0] core_ready,
    input  logic [N_CORES-1:0] core_ack,
    output logic               running,
    output logic               tgt_valid,
    output logic [IDX_W-1:0]   tgt_idx,
    output logic [7:0]         err_bits,
    output logic [31:0]        ctrl_bits,
    output logic [N_CORES-1:0] sent,
    output logic               guest_err
);

    // ---------------- write strobes ----------------
    logic we_ctrl, we_err, we_tgt, we_move, we_start, we_stop;
    assign we_ctrl  = wr_en && (wr_addr == RA_CTRL);
    assign we_err   = wr_en && (wr_addr == RA_ERR);
    assign we_tgt   = wr_en && (wr_addr == RA_TARGET);
    assign we_move  = wr_en && (wr_addr == RA_MOVE);
    assign we_start = wr_en && (wr_addr == RA_START);
    assign we_stop  = wr_en && (wr_addr == RA_STOP);

    logic unused_data;
    assign unused_data = ^{wr_data[31:SEL_MODE_BIT+1], wr_data[SEL_MODE_BIT-1:ERR_W]};

    // ---------------- target decode ----------------
    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_unimpl;

    tod_target_decode #(
        .N_CORES         (N_CORES),
        .IDX_W           (IDX_W),
        .CORE_BASES      (CORE_BASES),
        .CORE_IDS        (CORE_IDS),
        .TOD_OFS         (TOD_OFS),
        .CORE_ID_MODE_EN (CORE_ID_MODE_EN)
    ) u_dec (
        .sel_hi   (wr_data[63:32]),
        .sel_mode (wr_data[SEL_MODE_BIT]),
        .hit      (dec_hit),
        .hit_idx  (dec_idx),
        .unimpl   (dec_unimpl)
    );

    // ---------------- state register ----------------
    tod_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (we_start) state_d = ST_RUNNING; // T_START
            ST_RUNNING: if (we_stop)  state_d = ST_STOPPED; // T_STOP
            default:    state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // ---------------- command outcomes ----------------
    logic [ERR_W-1:0]   err_set;
    logic [N_CORES-1:0] sent_set;
    logic               tgt_load;
    logic               tgt_valid_d;
    logic [IDX_W-1:0]   tgt_idx_d;

    always_comb begin
        err_set     = '0;
        sent_set    = '0;
        tgt_load    = 1'b0;
        tgt_valid_d = tgt_valid;
        tgt_idx_d   = tgt_idx;

        unique case (state_q)
            ST_STOPPED: begin
                if (we_stop)  err_set[EB_STOP_STATE] = 1'b1;
                if (we_move)  err_set[EB_MOVE_STATE] = 1'b1;
            end
            ST_RUNNING: begin
                if (we_start) err_set[EB_START_STATE] = 1'b1;
                if (we_move) begin
                    if (!wr_data[MOVE_CMD_BIT]) begin
                        err_set[EB_MOVE_CMD] = 1'b1;
                    end else if (!tgt_valid) begin
                        err_set[EB_MOVE_NOTGT] = 1'b1;
                    end else if (!core_ready[tgt_idx]) begin
                        err_set[EB_MOVE_NRDY] = 1'b1;
                    end else begin
                        sent_set[tgt_idx] = 1'b1;
                    end
                end
            end
            default: ;
        endcase

        if (we_tgt) begin
            tgt_load = 1'b1;
            if (dec_hit) begin
                tgt_valid_d = 1'b1;
                tgt_idx_d   = dec_idx;
            end else begin
                tgt_valid_d = 1'b0;
                tgt_idx_d   = '0;
                if (dec_unimpl) err_set[EB_UNIMPL] = 1'b1;
                else            err_set[EB_DECODE] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_valid <= 1'b0;
            tgt_idx   <= '0;
            ctrl_bits <= '0;
            guest_err <= 1'b0;
        end else begin
            if (tgt_load) begin
                tgt_valid <= tgt_valid_d;
                tgt_idx   <= tgt_idx_d;
            end
            if (we_ctrl) ctrl_bits <= wr_data[63:32];
            guest_err <= |err_set;
        end
    end

    assign running = (state_q == ST_RUNNING);

    // ---------------- sub-blocks ----------------
    tod_err_reg u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (we_err),
        .clr_mask (wr_data[ERR_W-1:0]),
        .set_vec  (err_set),
        .err      (err_bits)
    );

    tod_sent_flags #(.N_CORES(N_CORES)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (sent_set),
        .ready   (core_ready),
        .ack     (core_ack),
        .sent    (sent)
    );

    // ---------------- assertions ----------------
    // R6: RUNNING is entered only through START
    p_run_via_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(we_start));

    // R11: control field changes only on its own write
    p_ctrl_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !we_ctrl |=> $stable(ctrl_bits));

    // R12: guest error only follows a write
    p_guest_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        guest_err |-> $past(wr_en));

    // R2: latched index always names a real core
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> (int'(tgt_idx) < N_CORES));

endmodule

// File: tb/sim_tod_xfer_ctrl.sv
module sim_tod_xfer_ctrl;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [2:0]   wr_addr;
    logic [63:0]  wr_data;
    logic [N-1:0] core_ready;
    logic [N-1:0] core_ack;

    logic         running, tgt_valid, guest_err;
    logic [1:0]   tgt_idx;
    logic [7:0]   err_bits;
    logic [31:0]  ctrl_bits;
    logic [N-1:0] sent;

    logic         running1, tgt_valid1, guest_err1;
    logic [1:0]   tgt_idx1;
    logic [7:0]   err_bits1;
    logic [31:0]  ctrl_bits1;
    logic [N-1:0] sent1;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    tod_xfer_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .core_ready(core_ready), .core_ack(core_ack), .running(running),
        .tgt_valid(tgt_valid), .tgt_idx(tgt_idx), .err_bits(err_bits),
        .ctrl_bits(ctrl_bits), .sent(sent), .guest_err(guest_err)
    );

    // variant: core-number mode off, cores 1 and 2 share a base
    tod_xfer_ctrl #(
        .CORE_BASES({32'h2300_0000, 32'h2100_0000, 32'h2100_0000, 32'h2000_0000}),
        .CORE_ID_MODE_EN(1'b0)
    ) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .core_ready(core_ready), .core_ack(core_ack), .running(running1),
        .tgt_valid(tgt_valid1), .tgt_idx(tgt_idx1), .err_bits(err_bits1),
        .ctrl_bits(ctrl_bits1), .sent(sent1), .guest_err(guest_err1)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge; results are visible at the next falling edge
    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic logic [63:0] addr_word(input logic [31:0] a);
        return {a, 32'h1000_0000};           // bit 28 set: address mode
    endfunction

    function automatic logic [63:0] id_word(input logic [5:0] id);
        return {26'd0, id, 32'd0};           // bit 28 clear: core-number mode
    endfunction

    task automatic clr_all();
        wr(3'd1, 64'hFF);
    endtask

    task automatic t_reset();
        chk("R1", "running",   running,   0);
        chk("R1", "tgt_valid", tgt_valid, 0);
        chk("R1", "tgt_idx",   tgt_idx,   0);
        chk("R1", "err",       err_bits,  0);
        chk("R1", "ctrl",      ctrl_bits, 0);
        chk("R1", "sent",      sent,      0);
        chk("R1", "guest",     guest_err, 0);
    endtask

    task automatic t_ctrl();
        wr(3'd0, 64'hDEAD_BEEF_1234_5678);
        chk("R11", "ctrl upper half", ctrl_bits, 32'hDEAD_BEEF);
        wr(3'd0, 64'h0000_0001_FFFF_FFFF);
        chk("R11", "ctrl low half dropped", ctrl_bits, 32'h0000_0001);
    endtask

    task automatic t_state();
        wr(3'd4, 0);
        chk("R6", "start from stopped", running, 1);
        chk("R6", "no error", err_bits, 0);
        wr(3'd4, 0);
        chk("R6", "start while running err", err_bits, 8'h01);
        chk("R6", "still running", running, 1);
        chk("R12", "guest pulse high", guest_err, 1);
        @(negedge clk);
        chk("R12", "guest pulse one cycle", guest_err, 0);
        wr(3'd5, 0);
        chk("R6", "stop", running, 0);
        wr(3'd5, 0);
        chk("R6", "stop while stopped err", err_bits, 8'h81);
        clr_all();
        chk("R10", "clear all", err_bits, 0);
    endtask

    task automatic t_addr();
        wr(3'd2, addr_word(32'h2200_03A4));
        chk("R2", "addr core2 valid", tgt_valid, 1);
        chk("R2", "addr core2 idx", tgt_idx, 2);
        wr(3'd2, addr_word(32'h2000_03A4));
        chk("R2", "addr core0 idx", tgt_idx, 0);
        chk("R2", "addr core0 valid", tgt_valid, 1);
        wr(3'd2, addr_word(32'h2000_03A8));
        chk("R3", "bad offset clears valid", tgt_valid, 0);
        chk("R3", "bad offset err", err_bits, 8'h20);
        chk("R12", "bad offset guest", guest_err, 1);
        clr_all();
        wr(3'd2, addr_word(32'h3000_03A4));
        chk("R3", "no base match valid", tgt_valid, 0);
        chk("R3", "no base match err", err_bits, 8'h20);
        clr_all();
    endtask

    task automatic t_coreid();
        wr(3'd2, id_word(6'd9));
        chk("R4", "id 9 -> core2 valid", tgt_valid, 1);
        chk("R4", "id 9 -> core2", tgt_idx, 2);
        wr(3'd2, id_word(6'h20 | 6'd5));
        chk("R4", "id masked to 5 bits -> core1", tgt_idx, 1);
        wr(3'd2, id_word(6'd13));
        chk("R4", "id 13 -> core3", tgt_idx, 3);
        wr(3'd2, id_word(6'd7));
        chk("R4", "unknown id clears valid", tgt_valid, 0);
        chk("R4", "unknown id err", err_bits, 8'h20);
        clr_all();
    endtask

    task automatic t_move_guards();
        core_ready = '1;
        wr(3'd2, addr_word(32'h2200_03A4));
        wr(3'd3, 64'h8000_0000_0000_0000);
        chk("R7", "move while stopped", err_bits, 8'h02);
        chk("R7", "no sent when stopped", sent, 0);
        clr_all();
        wr(3'd4, 0);
        wr(3'd3, 64'h0);
        chk("R7", "move cmd bit clear", err_bits, 8'h04);
        clr_all();
        wr(3'd2, id_word(6'd7));
        clr_all();
        wr(3'd3, 64'h0);
        chk("R7", "cmd check before target check", err_bits, 8'h04);
        clr_all();
        wr(3'd3, 64'h8000_0000_0000_0000);
        chk("R7", "move without target", err_bits, 8'h08);
        chk("R7", "no sent without target", sent, 0);
        clr_all();
    endtask

    task automatic t_ready_ack();
        core_ready = 4'b1011;
        wr(3'd2, addr_word(32'h2200_03A4));
        wr(3'd3, 64'h8000_0000_0000_0000);
        chk("R8", "not ready err", err_bits, 8'h10);
        chk("R8", "not ready no sent", sent, 0);
        clr_all();
        core_ready = 4'b0100;
        wr(3'd3, 64'h8000_0000_0000_0000);
        chk("R8", "sent core2", sent, 4'b0100);
        chk("R8", "no error on success", err_bits, 0);
        chk("R12", "no guest on success", guest_err, 0);
        core_ready = '0;
        repeat (3) @(negedge clk);
        chk("R9", "sent holds", sent, 4'b0100);
        core_ack = 4'b1011;
        @(negedge clk);
        core_ack = '0;
        chk("R9", "other acks ignored", sent, 4'b0100);
        core_ack = 4'b0100;
        @(negedge clk);
        core_ack = '0;
        chk("R9", "ack clears", sent, 0);
    endtask

    task automatic t_w1c();
        wr(3'd2, id_word(6'd7));
        wr(3'd4, 0);                          // running already: error bit 0
        chk("R10", "two errors", err_bits, 8'h21);
        wr(3'd1, 64'h01);
        chk("R10", "clear bit0 only", err_bits, 8'h20);
        wr(3'd1, 64'h00);
        chk("R10", "zero mask no effect", err_bits, 8'h20);
        wr(3'd1, 64'hFF);
        chk("R10", "clear rest", err_bits, 0);
    endtask

    task automatic t_variant();
        clr_all();
        wr(3'd2, id_word(6'd5));
        chk("R5", "variant no target", tgt_valid1, 0);
        chk("R5", "variant unimpl err", err_bits1, 8'h40);
        chk("R5", "variant guest", guest_err1, 1);
        chk("R4", "full unit accepts id", tgt_idx, 1);
        clr_all();
        wr(3'd2, addr_word(32'h2100_03A4));
        chk("R2", "first match wins", tgt_idx1, 1);
        chk("R2", "variant addr valid", tgt_valid1, 1);
        chk("R2", "variant no error", err_bits1, 0);
    endtask

    logic done = 1'b0;

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        core_ready = '0; core_ack = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_state();
        t_addr();
        t_coreid();
        t_move_guards();
        t_ready_ack();
        t_w1c();
        t_variant();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule